// File: doc/BRIEF.md
# Unprivileged Byte-Store Execute Unit

This unit takes one unprivileged byte-store instruction per transaction and carries it to a memory write and an optional base-register update. It accepts three encodings. Two are 32-bit words: one with a 12-bit immediate and one with a shifted index register. The third is a compact form made of two halfwords. The caller marks the compact form with `in_compact`. In that case the first halfword sits in `in_instr[31:16]` and the second in `in_instr[15:0]`.

The unit drives three register-file read addresses from the instruction fields and samples the combinational read data on the accepting edge. It registers a single result and holds it until the consumer takes it. The memory write, the base writeback and the undefined-instruction pulse are asserted only in the cycle where `out_valid` and `out_ready` are both high. The enclosing pipeline reduces the condition check to `in_cond_pass` and reports hypervisor privilege on `in_hyp`.

Top module: `ubst_unit`

## Requirements
- R1: Immediate form, selected when `in_compact`=0, bits[27:24]=0100, bits[22:20]=110 and bits[31:28]≠1111. U is bit 23, the base index is bits[19:16], the data index is bits[15:12] and imm12 is bits[11:0]. The memory address is the unmodified base. The base register is then written with base+imm12 when U=1, or base−imm12 when U=0.
- R2: Register form, selected by bits[27:24]=0110, bits[22:20]=110, bit 4=0 and bits[31:28]≠1111. The shift amount is bits[11:7], the type is bits[6:5] and the index is bits[3:0]. The offset is the index shifted as follows: type 00 is a left shift; type 01 is a logical right shift; type 10 is an arithmetic right shift. For types 01 and 10 an amount of 0 means 32. Addressing and writeback follow R1.
- R3: In the register form, type 11 with a nonzero amount rotates right. With amount 0 it rotates right by one bit, and `in_carry` enters at bit 31.
- R4: Compact form, selected by `in_compact`=1, `in_instr[31:20]`=F80 and `in_instr[11:8]`=1110. The base index is `in_instr[19:16]`, the data index is `in_instr[15:12]` and imm8 is `in_instr[7:0]`. The address is base+imm8 and no writeback occurs.
- R5: A store writes only bits[7:0] of the data register. That byte is replicated into all four lanes of `mem_wdata`. `mem_strb` has exactly bit address[1:0] set, and `mem_user` is 1.
- R6: If the data index is 15, the base index is 15, the two are equal, or (register form only) the index register is 15 in a 32-bit form, the unit raises `out_undef`. The same applies to a data index of 15 in the compact form. In every such case there is no memory write and no writeback.
- R7: A word matching none of the three layouts (including condition 1111), or a compact form with base index 15, raises `out_undef` whatever the condition flag.
- R8: A valid instruction whose condition passes while `in_hyp`=1 raises `out_undef` with no side effects.
- R9: When `in_cond_pass`=0 for a valid encoding, the transaction completes with no write, no writeback and no undef.
- R10: At most one instruction is in flight: `in_ready` is low while `out_valid` is high. Outputs are held stable, and side-effect strobes stay low, until `out_ready`.
- R11: After reset `out_valid`=0, `in_ready`=1 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| in_valid | input | 1 | instruction offered |
| in_ready | output | 1 | unit can accept |
| in_instr | input | 32 | instruction word or two halfwords |
| in_compact | input | 1 | word holds the compact two-halfword form |
| in_cond_pass | input | 1 | condition check passed |
| in_hyp | input | 1 | executing at hypervisor level |
| in_carry | input | 1 | carry flag for rotate-with-extend |
| rf_n_addr | output | 4 | base register read address |
| rf_n_data | input | 32 | base register value |
| rf_t_addr | output | 4 | data register read address |
| rf_t_data | input | 32 | data register value |
| rf_m_addr | output | 4 | index register read address |
| rf_m_data | input | 32 | index register value |
| out_valid | output | 1 | result held |
| out_ready | input | 1 | consumer takes result |
| out_undef | output | 1 | undefined-instruction pulse |
| mem_we | output | 1 | byte write request |
| mem_user | output | 1 | access uses user privilege |
| mem_addr | output | 32 | byte address |
| mem_wdata | output | 32 | replicated byte |
| mem_strb | output | 4 | one-hot lane strobe |
| wb_en | output | 1 | base writeback |
| wb_addr | output | 4 | writeback register |
| wb_data | output | 32 | updated base |

## Verification
Random words spread over the three layouts with random register contents. Each shift type is tried with zero and nonzero amounts, so the 32-bit special cases and the carry-in rotate are told apart from plain shifts. Directed words separate the trap sources: a field conflict, index 15, a bad layout, hypervisor level, and a failed condition that must stay silent. Base values with each low-two-bit pattern, and both U settings, show whether the lane strobe and the sign of the writeback follow the address.

// File: rtl/ubst_pkg.sv
package ubst_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 4;
    localparam logic [RIDX_W-1:0] PC_IDX = '1;

    typedef enum logic [1:0] {SH_LSL = 2'b00, SH_LSR = 2'b01, SH_ASR = 2'b10, SH_ROR = 2'b11} shift_e;
    typedef enum logic [1:0] {F_IMM, F_REG, F_CMP, F_BAD} form_e;

    typedef struct packed {
        form_e             form;
        logic [RIDX_W-1:0] rn;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rm;
        logic              add;
        logic              post;
        logic [XLEN-1:0]   imm;
        shift_e            stype;
        logic [4:0]        samt;
        logic              hard_undef;
        logic              unpred;
    } dec_t;

    typedef struct packed {
        logic              busy;
        logic              undef;
        logic              do_mem;
        logic              do_wb;
        logic [XLEN-1:0]   addr;
        logic [7:0]        data;
        logic [RIDX_W-1:0] wb_reg;
        logic [XLEN-1:0]   wb_val;
    } state_t;
endpackage

// File: rtl/ubst_decode.sv
module ubst_decode
    import ubst_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        compact,
    output dec_t        dec
);
    logic word_ok;

    always_comb begin
        dec         = '0;
        dec.form    = F_BAD;
        dec.stype   = SH_LSL;
        dec.rn      = instr[19:16];
        dec.rt      = instr[15:12];
        word_ok     = 1'b0;
        if (compact) begin
            word_ok        = (instr[31:20] == 12'hF80) && (instr[11:8] == 4'hE);
            dec.form       = word_ok ? F_CMP : F_BAD;
            dec.add        = 1'b1;
            dec.post       = 1'b0;
            dec.imm        = {{(XLEN-8){1'b0}}, instr[7:0]};
            dec.hard_undef = !word_ok || (dec.rn == PC_IDX);
            dec.unpred     = (dec.rt == PC_IDX);
        end else begin
            word_ok  = (instr[31:28] != 4'hF) && !instr[24] && (instr[22:20] == 3'b110);
            dec.add  = instr[23];
            dec.post = 1'b1;
            if (word_ok && instr[27:25] == 3'b010) begin
                dec.form   = F_IMM;
                dec.imm    = {{(XLEN-12){1'b0}}, instr[11:0]};
                dec.unpred = (dec.rt == PC_IDX) || (dec.rn == PC_IDX) || (dec.rn == dec.rt);
            end else if (word_ok && instr[27:25] == 3'b011 && !instr[4]) begin
                dec.form   = F_REG;
                dec.rm     = instr[3:0];
                dec.samt   = instr[11:7];
                dec.stype  = shift_e'(instr[6:5]);
                dec.unpred = (dec.rt == PC_IDX) || (dec.rn == PC_IDX) ||
                             (dec.rn == dec.rt) || (dec.rm == PC_IDX);
            end
            dec.hard_undef = (dec.form == F_BAD);
        end
    end
endmodule

// File: rtl/ubst_shift.sv
module ubst_shift
    import ubst_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] x,
    input  shift_e       kind,
    input  logic [4:0]   amt,
    input  logic         carry,
    output logic [W-1:0] y
);
    localparam int AW = $clog2(W) + 1;
    logic [AW-1:0] n;
    logic [AW-1:0] back;

    always_comb begin
        n    = AW'(amt);
        back = AW'(W) - n;
        unique case (kind)
            SH_LSL: y = x << n;
            SH_LSR: y = (amt == '0) ? '0 : (x >> n);
            SH_ASR: y = (amt == '0) ? {W{x[W-1]}} : W'($signed(x) >>> n);
            default: y = (amt == '0) ? {carry, x[W-1:1]} : ((x >> n) | (x << back));
        endcase
    end
endmodule

// File: rtl/ubst_unit.sv
module ubst_unit
    import ubst_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_instr,
    input  logic              in_compact,
    input  logic              in_cond_pass,
    input  logic              in_hyp,
    input  logic              in_carry,
    output logic [RIDX_W-1:0] rf_n_addr,
    input  logic [DW-1:0]     rf_n_data,
    output logic [RIDX_W-1:0] rf_t_addr,
    input  logic [DW-1:0]     rf_t_data,
    output logic [RIDX_W-1:0] rf_m_addr,
    input  logic [DW-1:0]     rf_m_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_undef,
    output logic              mem_we,
    output logic              mem_user,
    output logic [DW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [DW/8-1:0]   mem_strb,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_addr,
    output logic [DW-1:0]     wb_data
);
    localparam int LANES = DW / 8;
    localparam int LSB_W = $clog2(LANES);

    dec_t          dec;
    logic [DW-1:0] shifted;
    logic [DW-1:0] offset;
    logic [DW-1:0] new_base;
    logic          go;
    logic          fire;
    state_t        st_d, st_q;

    ubst_decode u_dec (.instr(in_instr), .compact(in_compact), .dec(dec));

    ubst_shift #(.W(DW)) u_shf (
        .x(rf_m_data), .kind(dec.stype), .amt(dec.samt), .carry(in_carry), .y(shifted)
    );

    assign rf_n_addr = dec.rn;
    assign rf_t_addr = dec.rt;
    assign rf_m_addr = dec.rm;

    always_comb begin
        offset   = (dec.form == F_REG) ? shifted : dec.imm;
        new_base = dec.add ? (rf_n_data + offset) : (rf_n_data - offset);
        go       = !dec.hard_undef && in_cond_pass && !in_hyp && !dec.unpred;
        st_d     = st_q;
        if (st_q.busy && out_ready) begin
            st_d.busy = 1'b0;
        end
        if (!st_q.busy && in_valid) begin
            st_d.busy   = 1'b1;
            st_d.undef  = dec.hard_undef || (in_cond_pass && (in_hyp || dec.unpred));
            st_d.do_mem = go;
            st_d.do_wb  = go && dec.post;
            st_d.addr   = dec.post ? rf_n_data : new_base;
            st_d.data   = rf_t_data[7:0];
            st_d.wb_reg = dec.rn;
            st_d.wb_val = new_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire      = st_q.busy && out_ready;
    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign out_undef = fire && st_q.undef;
    assign mem_we    = fire && st_q.do_mem;
    assign mem_user  = mem_we;
    assign mem_addr  = st_q.addr;
    assign mem_wdata = {LANES{st_q.data}};
    assign wb_en     = fire && st_q.do_wb;
    assign wb_addr   = st_q.wb_reg;
    assign wb_data   = st_q.wb_val;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mem_strb[g] = (st_q.addr[LSB_W-1:0] == LSB_W'(g));
    end

    AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $countones(mem_strb) == 1) else $error("lane"); // R5
    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> !mem_we && !wb_en) else $error("undef side effect"); // R6
    AST_WB_NOT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_addr != PC_IDX) else $error("pc writeback"); // R6
    AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready) else $error("ready"); // R10
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(mem_addr) && $stable(wb_data))
        else $error("hold"); // R10
    AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> !mem_we && !wb_en && !out_undef) else $error("gating"); // R10
endmodule

// File: tb/ubst_unit_tb.sv
module ubst_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, in_compact = 0, in_cond_pass = 1, in_hyp = 0, in_carry = 0;
    logic [31:0] in_instr = '0;
    logic        out_ready = 0;
    logic        in_ready, out_valid, out_undef, mem_we, mem_user, wb_en;
    logic [3:0]  rf_n_addr, rf_t_addr, rf_m_addr, wb_addr, mem_strb;
    logic [31:0] rf_n_data, rf_t_data, rf_m_data, mem_addr, mem_wdata, wb_data;
    logic [31:0] rf [16];
    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rf_n_data = rf[rf_n_addr];
    assign rf_t_data = rf[rf_t_addr];
    assign rf_m_data = rf[rf_m_addr];

    ubst_unit u_dut (.*);

    typedef struct {
        bit undef, mem, wb;
        logic [31:0] addr, wdata, wbval;
        logic [3:0]  strb, wbreg;
        string tag;
    } exp_t;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    function automatic logic [31:0] shref(logic [31:0] x, logic [1:0] ty, logic [4:0] a, logic c);
        int n = (a == 0 && ty != 0) ? 32 : int'(a);
        logic [63:0] w;
        case (ty)
            2'd0: return x << a;
            2'd1: begin w = {32'b0, x} >> n; return w[31:0]; end
            2'd2: begin w = {{32{x[31]}}, x} >> n; return w[31:0]; end
            default: begin
                if (a == 0) return {c, x[31:1]};
                w = {x, x} >> a; return w[31:0];
            end
        endcase
    endfunction

    function automatic exp_t model(logic [31:0] i, bit cmp, bit cp, bit hyp, bit cy);
        exp_t e;
        int kind;  // 0 imm, 1 reg, 2 compact, 3 bad
        logic [3:0] n = i[19:16], t = i[15:12], m = i[3:0];
        logic [31:0] off, nb;
        bit up, bad;
        e = '{default: 0, tag: ""};
        if (cmp) kind = (i[31:20] == 12'hF80 && i[11:8] == 4'hE) ? 2 : 3;
        else if (i[31:28] == 4'hF || i[24] || i[22:20] != 3'b110) kind = 3;
        else if (i[27:25] == 3'b010) kind = 0;
        else if (i[27:25] == 3'b011 && !i[4]) kind = 1;
        else kind = 3;
        e.tag = kind == 0 ? "R1" : kind == 1 ? (i[6:5] == 2'b11 ? "R3" : "R2") : "R4";
        if (kind == 3 || (kind == 2 && n == 15)) begin e.undef = 1; e.tag = "R7"; return e; end
        if (!cp) begin e.tag = "R9"; return e; end
        if (hyp) begin e.undef = 1; e.tag = "R8"; return e; end
        bad = (t == 15) || (kind != 2 && (n == 15 || n == t)) || (kind == 1 && m == 15);
        if (bad) begin e.undef = 1; e.tag = "R6"; return e; end
        up  = (kind == 2) ? 1'b1 : i[23];
        off = kind == 0 ? {20'b0, i[11:0]} : kind == 2 ? {24'b0, i[7:0]} :
              shref(rf[m], i[6:5], i[11:7], cy);
        nb  = up ? rf[n] + off : rf[n] - off;
        e.mem   = 1;
        e.addr  = (kind == 2) ? nb : rf[n];
        e.wdata = {4{rf[t][7:0]}};
        e.strb  = 4'b0001 << e.addr[1:0];
        e.wb    = (kind != 2);
        e.wbreg = n;
        e.wbval = nb;
        return e;
    endfunction

    task automatic run(logic [31:0] i, bit cmp, bit cp, bit hyp, bit cy, int wait_n);
        exp_t e;
        @(negedge clk);
        in_instr = i; in_compact = cmp; in_cond_pass = cp; in_hyp = hyp; in_carry = cy;
        e = model(i, cmp, cp, hyp, cy);
        in_valid = 1;
        @(negedge clk);
        in_valid = 0;
        chk("R10", "out_valid", out_valid, 1);
        chk("R10", "in_ready busy", in_ready, 0);
        repeat (wait_n) begin
            @(negedge clk);
            chk("R10", "held strobes", {mem_we, wb_en, out_undef}, 0);
        end
        out_ready = 1;
        #1;
        chk(e.tag, "undef", out_undef, e.undef);
        chk(e.tag, "mem_we", mem_we, e.mem);
        chk(e.tag, "wb_en", wb_en, e.wb);
        if (e.mem) begin
            chk(e.tag, "addr", mem_addr, e.addr);
            chk("R5", "wdata", mem_wdata, e.wdata);
            chk("R5", "strb", mem_strb, e.strb);
            chk("R5", "user", mem_user, 1);
        end
        if (e.wb) begin
            chk(e.tag, "wb_addr", wb_addr, e.wbreg);
            chk(e.tag, "wb_data", wb_data, e.wbval);
        end
        @(negedge clk);
        out_ready = 0;
        chk("R10", "released", out_valid, 0);
    endtask

    function automatic logic [31:0] a1(logic [3:0] c, bit u, logic [3:0] n, t, logic [11:0] im);
        return {c, 4'b0100, u, 3'b110, n, t, im};
    endfunction
    function automatic logic [31:0] a2(logic [3:0] c, bit u, logic [3:0] n, t, logic [4:0] a,
                                       logic [1:0] ty, logic [3:0] m);
        return {c, 4'b0110, u, 3'b110, n, t, a, ty, 1'b0, m};
    endfunction
    function automatic logic [31:0] t1(logic [3:0] n, t, logic [7:0] im);
        return {12'hF80, n, t, 4'hE, im};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int k = 0; k < 16; k++) rf[k] = $urandom;
        rf[2] = 32'h8000_1003; rf[5] = 32'hA5A5_5A7E; rf[7] = 32'h0000_0004;
        #(CLK_PERIOD * 2 + 2);
        // R11 reset state
        chk("R11", "out_valid", out_valid, 0);
        chk("R11", "in_ready", in_ready, 1);
        chk("R11", "strobes", {mem_we, wb_en, out_undef}, 0);
        rst_n = 1;
        // R1 both directions
        run(a1(4'hE, 1, 2, 5, 12'hFFF), 0, 1, 0, 0, 0);
        run(a1(4'h0, 0, 2, 5, 12'h010), 0, 1, 0, 0, 2);
        // R2, R3 every type, zero and nonzero amounts
        for (int ty = 0; ty < 4; ty++) begin
            run(a2(4'hE, 1, 2, 5, 5'd0, ty[1:0], 7), 0, 1, 0, 1, 0);
            run(a2(4'hE, 0, 2, 5, 5'd3, ty[1:0], 2 + 1), 0, 1, 0, 0, 1);
        end
        run(a2(4'hE, 1, 2, 5, 5'd0, 2'b11, 7), 0, 1, 0, 0, 0);  // R3 carry 0
        // R4 compact, R5 lanes
        for (int l = 0; l < 4; l++) begin
            rf[9] = 32'h1000_0000 + l;
            run(t1(9, 5, 8'h00), 1, 1, 0, 0, 0);
        end
        run(t1(2, 5, 8'hFF), 1, 1, 0, 0, 0);
        // R6 conflicts
        run(a1(4'hE, 1, 5, 5, 12'h4), 0, 1, 0, 0, 0);
        run(a1(4'hE, 1, 15, 5, 12'h4), 0, 1, 0, 0, 0);
        run(a2(4'hE, 1, 2, 5, 5'd1, 2'b00, 15), 0, 1, 0, 0, 0);
        run(t1(2, 15, 8'h1), 1, 1, 0, 0, 0);
        // R7 bad encodings
        run(a1(4'hF, 1, 2, 5, 12'h4), 0, 1, 0, 0, 0);
        run(t1(15, 5, 8'h1), 1, 0, 0, 0, 0);
        run(a2(4'hE, 1, 2, 5, 5'd1, 2'b00, 7) | 32'h10, 0, 1, 0, 0, 0);
        // R8 hypervisor, R9 condition fail
        run(a1(4'hE, 1, 2, 5, 12'h4), 0, 1, 1, 0, 0);
        run(a1(4'hE, 1, 2, 5, 12'h4), 0, 0, 1, 0, 0);
        run(t1(2, 15, 8'h1), 1, 0, 0, 0, 0);
        // random mix
        for (int r = 0; r < 400; r++) begin
            logic [31:0] w = $urandom;
            int sel = $urandom_range(0, 9);
            for (int k = 0; k < 16; k++) rf[k] = $urandom;
            if (sel < 3) w = a1(w[31:28], w[23], w[19:16], w[15:12], w[11:0]);
            else if (sel < 6) w = a2(w[31:28], w[23], w[19:16], w[15:12], w[11:7], w[6:5], w[3:0]);
            else if (sel < 9) w = t1(w[19:16], w[15:12], w[7:0]);
            run(w, sel >= 6 && sel < 9 ? 1'b1 : 1'($urandom_range(0, 1) & (sel == 9)),
                $urandom_range(0, 9) != 0, $urandom_range(0, 19) == 0,
                1'($urandom_range(0, 1)), $urandom_range(0, 2));
        end
        summary();
    end
endmodule